// File: doc/BRIEF.md
# Programmable Pin Glitch Filter Bank

This block cleans up a bank of asynchronous digital pin inputs before the rest of the chip sees them. Each raw input is first brought into the clock domain through a two-flop synchronizer. An enabled pin then runs through its own digital filter. The filter holds its output until the synchronized input has differed from it for more clock cycles than the shared length setting. Any shorter excursion is absorbed without a trace. A pin whose filter is off shows the synchronized level directly.

All pins use one length threshold, held in a 32-bit register with a 5-bit field. Software sets the threshold through a simple synchronous write port and can read it back. The threshold can only change while every filter is switched off. A write made while any filter is on is dropped, and it sets an error flag that stays set until reset. The filter works the same way whatever function the pin is muxed to, so the block has no knowledge of pin muxing.

Top module: `pgf_top`

## Requirements
- R1: After reset the length register reads 0, every filtered output is 0 and the write-error flag is 0.
- R2: Each raw input passes through two synchronizer flops and then the output register. A level that is first sampled at rising edge e0 appears on a disabled pin's output after edge e0+2.
- R3: A pin whose enable bit is 0 shows its synchronized input on its output one edge later, whatever its earlier filter history. Its counter is held at zero, so enabling it again starts a fresh count.
- R4: On an enabled pin, an input excursion lasting L or fewer clock cycles, where L is the current length, leaves the output unchanged.
- R5: On an enabled pin, an input level held for more than L cycles reaches the output. The change is visible after rising edge e0+L+2, where e0 is the first edge that samples the new level.
- R6: With L = 0, an enabled pin passes every change, including a single-cycle pulse.
- R7: The register read data carries the length in bits 4:0. Bits 31:5 always read 0, and the values written to them have no effect.
- R8: A write strobe made while the enable vector is all zeros loads bits 4:0 of the write data into the length. The new value reads back after the next edge.
- R9: A write strobe made while any enable bit is 1 leaves the length unchanged and sets the write-error flag.
- R10: Once set, the write-error flag stays 1 until reset, including across later writes that are accepted.
- R11: Each pin keeps its own count, so pulses of different widths on different pins at the same time are filtered independently.
- R12: When the input returns to the output level, the count restarts from zero. Two excursions of L cycles each, separated by a single cycle at the output level, are both absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the length register |
| reg_wdata | input | 32 | Write data; bits 4:0 carry the length |
| reg_rdata | output | 32 | Length register read data |
| len_wr_err | output | 1 | Sticky flag: a length write was refused |
| filt_en | input | 32 | Per-pin filter enable |
| pin_raw | input | 32 | Asynchronous raw pin levels |
| pin_filt | output | 32 | Filtered pin levels |

## Verification
The filter is driven with single pulses swept in width around the threshold, to separate "absorbed" from "passed" and to pin the latency to the exact edge. Different pins receive pulses of different widths at the same time, to show that their counters do not interact. Interrupted pulse trains show that the count restarts rather than accumulates. Long runs of random levels, with enables toggled mid-count, compare every pin on every cycle against a behavioural model. Register writes are made both with all filters off and with some filters on, which separates an accepted update from a refused one and confirms that the error flag stays set.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int unsigned PGF_REG_W  = 32;
  localparam int unsigned PGF_LEN_W  = 5;
  localparam int unsigned PGF_PINS   = 32;
  localparam int unsigned PGF_SYNC_N = 2;

  typedef struct packed {
    logic                 strobe;
    logic [PGF_REG_W-1:0] data;
  } pgf_wr_t;
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pgf_len_reg.sv
module pgf_len_reg
  import pgf_pkg::*;
#(
  parameter int unsigned LEN_W = 5,
  parameter int unsigned REG_W = 32,
  parameter int unsigned PINS  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pgf_wr_t          wr,
  input  logic [PINS-1:0]  filt_en,
  output logic [LEN_W-1:0] len_q,
  output logic [REG_W-1:0] rdata,
  output logic             err_q
);
  logic             any_on;
  logic             len_ce;
  logic [LEN_W-1:0] len_d;
  logic             err_d;

  assign any_on = |filt_en;

  always_comb begin
    len_ce = wr.strobe && !any_on;
    len_d  = wr.data[LEN_W-1:0];
    err_d  = err_q | (wr.strobe & any_on);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_ce) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rdata = {{(REG_W-LEN_W){1'b0}}, len_q};
endmodule

// File: rtl/pgf_pin_filter.sv
module pgf_pin_filter #(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_in,
  input  logic [LEN_W-1:0] len,
  output logic             out_q
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             out_d;
  logic             differs;

  assign differs = sync_in ^ out_q;

  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (!en) begin
      out_d = sync_in;
    end else if (differs) begin
      if (cnt_q >= len) out_d = sync_in;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/pgf_top.sv
module pgf_top
  import pgf_pkg::*;
#(
  parameter int unsigned PINS   = PGF_PINS,
  parameter int unsigned LEN_W  = PGF_LEN_W,
  parameter int unsigned REG_W  = PGF_REG_W,
  parameter int unsigned SYNC_N = PGF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             len_wr_err,
  input  logic [PINS-1:0]  filt_en,
  input  logic [PINS-1:0]  pin_raw,
  output logic [PINS-1:0]  pin_filt
);
  logic [PINS-1:0]  sync_q;
  logic [LEN_W-1:0] len_q;
  pgf_wr_t          wr;

  assign wr.strobe = reg_wr_en;
  assign wr.data   = reg_wdata;

  pgf_sync #(.WIDTH(PINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_raw), .sync_out(sync_q)
  );

  pgf_len_reg #(.LEN_W(LEN_W), .REG_W(REG_W), .PINS(PINS)) u_len (
    .clk(clk), .rst_n(rst_n), .wr(wr), .filt_en(filt_en),
    .len_q(len_q), .rdata(reg_rdata), .err_q(len_wr_err)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pgf_pin_filter #(.LEN_W(LEN_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .en(filt_en[p]), .sync_in(sync_q[p]),
      .len(len_q), .out_q(pin_filt[p])
    );
  end
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int unsigned PINS  = 32,
  parameter int unsigned LEN_W = 5,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_rdata,
  input logic             len_wr_err,
  input logic [PINS-1:0]  filt_en,
  input logic [PINS-1:0]  pin_filt,
  input logic [PINS-1:0]  sync_q,
  input logic [LEN_W-1:0] len_q
);
  // R3: a disabled pin copies its synchronized level one edge later
  assert_disabled_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_filt & ~$past(filt_en)) == ($past(sync_q) & ~$past(filt_en))));

  // R4 / R5: an output bit only ever moves toward the synchronized level
  assert_moves_to_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_filt ^ $past(pin_filt)) & (pin_filt ^ $past(sync_q))) == '0));

  // R7: upper read bits stay zero
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:LEN_W] == '0);

  // R9: refused write keeps the length and raises the flag
  assert_refused_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (filt_en != '0)) |=> ($stable(len_q) && len_wr_err));

  // R10: the error flag never clears
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr_err |=> len_wr_err);

  // R8: length changes only on a write strobe
  assert_len_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(len_q));
endmodule

bind pgf_top pgf_checker #(.PINS(PINS), .LEN_W(LEN_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata),
  .len_wr_err(len_wr_err), .filt_en(filt_en), .pin_filt(pin_filt),
  .sync_q(sync_q), .len_q(len_q)
);

// File: tb/sim_pgf_top.sv
`timescale 1ns/1ps
module sim_pgf_top;
  localparam int PINS = 32;
  localparam int LW   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        len_wr_err;
  logic [31:0] filt_en;
  logic [31:0] pin_raw;
  logic [31:0] pin_filt;

  always #2.5 clk = ~clk;

  pgf_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .len_wr_err(len_wr_err), .filt_en(filt_en),
    .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  int    vectors = 0;
  int    misses  = 0;
  int    cyc     = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;

  // behavioural reference
  bit [31:0] m_s1, m_s2, m_out;
  int        age [PINS];
  int        m_len;
  bit        m_err;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_out = '0; m_len = 0; m_err = 1'b0;
      for (int i = 0; i < PINS; i++) age[i] = 0;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        if (!filt_en[i]) begin
          m_out[i] = m_s2[i]; age[i] = 0;
        end else if (m_s2[i] != m_out[i]) begin
          age[i]++;
          if (age[i] > m_len) begin m_out[i] = m_s2[i]; age[i] = 0; end
        end else begin
          age[i] = 0;
        end
      end
      m_s2 = m_s1;
      m_s1 = pin_raw;
      if (reg_wr_en) begin
        if (filt_en == '0) m_len = int'(reg_wdata[LW-1:0]);
        else               m_err = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      check(cur_req, "pins", pin_filt, m_out);
      check(cur_req, "rdata", reg_rdata, 32'(m_len));
      check(cur_req, "err", {31'b0, len_wr_err}, {31'b0, m_err});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      misses++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_len(logic [31:0] d);
    reg_wr_en = 1'b1; reg_wdata = d;
    tick(1);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; filt_en = '0; pin_raw = '0;
    tick(3);
    check("R1", "rdata", reg_rdata, 32'h0);
    check("R1", "pins", pin_filt, 32'h0);
    check("R1", "err", {31'b0, len_wr_err}, 32'h0);
    rst_n = 1'b1;
    run_cmp = 1'b1;

    // R2: latency through synchronizer, filters off
    cur_req = "R2";
    pin_raw[7] = 1'b1;
    tick(2); check("R2", "pin7 early", {31'b0, pin_filt[7]}, 32'h0);
    tick(1); check("R2", "pin7 late", {31'b0, pin_filt[7]}, 32'h1);
    cur_req = "R3";
    for (int k = 0; k < 60; k++) begin pin_raw = $urandom; tick(1); end
    pin_raw = '0; tick(4);

    // R7 / R8: load length 3 with all filters off; upper bits ignored
    cur_req = "R8";
    write_len(32'hFFFF_FFE3);
    check("R7", "upper bits", reg_rdata, 32'h3);
    check("R8", "len loaded", reg_rdata, 32'h3);

    filt_en = '1; tick(2);
    // R4: pulse of L=3 absorbed
    cur_req = "R4";
    pin_raw[3] = 1'b1; tick(3); pin_raw[3] = 1'b0; tick(8);
    check("R4", "pin3 absorbed", {31'b0, pin_filt[3]}, 32'h0);
    // R5: level held past L reaches output after edge e0+L+2
    cur_req = "R5";
    pin_raw[2] = 1'b1;
    tick(5); check("R5", "pin2 before", {31'b0, pin_filt[2]}, 32'h0);
    tick(1); check("R5", "pin2 after", {31'b0, pin_filt[2]}, 32'h1);
    pin_raw[2] = 1'b0; tick(10);
    // R11: concurrent pulses of different widths
    cur_req = "R11";
    for (int w = 1; w <= 6; w++) begin
      pin_raw[0] = 1'b1; pin_raw[5] = 1'b1;
      tick(w); pin_raw[0] = 1'b0;
      tick(7 - w); pin_raw[5] = 1'b0;
      tick(12);
    end
    // R12: count restarts after a one-cycle return
    cur_req = "R12";
    pin_raw[1] = 1'b1; tick(3); pin_raw[1] = 1'b0; tick(1);
    pin_raw[1] = 1'b1; tick(3); pin_raw[1] = 1'b0; tick(8);
    check("R12", "pin1 absorbed", {31'b0, pin_filt[1]}, 32'h0);

    // R9: write refused while enabled
    cur_req = "R9";
    write_len(32'h0000_0000);
    check("R9", "len kept", reg_rdata, 32'h3);
    check("R9", "err set", {31'b0, len_wr_err}, 32'h1);

    // R10: accepted write leaves the flag set
    cur_req = "R10";
    filt_en = '0; tick(2);
    write_len(32'h0);
    check("R10", "len zero", reg_rdata, 32'h0);
    check("R10", "err sticky", {31'b0, len_wr_err}, 32'h1);

    // R6: L = 0 passes a one-cycle pulse
    cur_req = "R6";
    filt_en = '1; tick(2);
    pin_raw[4] = 1'b1; tick(1); pin_raw[4] = 1'b0;
    tick(2); check("R6", "pin4 high", {31'b0, pin_filt[4]}, 32'h1);
    tick(1); check("R6", "pin4 low", {31'b0, pin_filt[4]}, 32'h0);

    // random traffic with enables toggled mid-count
    cur_req = "R3";
    for (int r = 0; r < 6; r++) begin
      filt_en = '0; tick(1);
      write_len(32'($urandom_range(0, 6)));
      filt_en = $urandom;
      for (int k = 0; k < 400; k++) begin
        if ($urandom_range(0, 3) == 0) pin_raw[$urandom_range(0, 31)] ^= 1'b1;
        if ($urandom_range(0, 40) == 0) filt_en = $urandom;
        tick(1);
      end
    end

    tick(4);
    run_cmp = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule